// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is a serial-peripheral-interface master with one shift engine and two holding registers: a transmit buffer that software fills and a receive buffer that software drains. Writing a byte to the transmit buffer is the only thing that starts a transfer. The byte moves into the shift engine as soon as the engine is idle, and the transmit buffer is then free for the next byte. Each character is eight bits, shifted most significant bit first. The serial clock idles low. Output data changes on the falling edge and input data is captured on the rising edge. Because receive and transmit happen together, reading a byte from a peripheral means sending one, which may be a dummy byte.

The serial clock is derived from the system clock. Each half period lasts `half_div` system cycles, so the divide factor is even and at least 2. The block has four status outputs. The transmit buffer can be free. A received character can be waiting. The transmitter can be fully idle. An error can be latched: a bus conflict or a receive overrun.

In four-pin operation, a grant input tells the master whether it owns the bus. While that input is low, the clock and data outputs are released to high impedance through their enable pins. The shift engine freezes without losing its state, and a sticky conflict error is raised. In three-pin operation the grant input is ignored.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, tx_free=1, tx_empty=1, rx_done=0, overrun=0, conflict_err=0, sclk_o=0, and both output enables are 1.
- R2: A tx_wr pulse clears tx_free from the next cycle on. When the engine is idle, the byte moves into the engine one cycle later: tx_free returns to 1 while tx_empty stays 0 until the character is finished.
- R3: mosi_o presents the transmit byte most significant bit first. The first bit is valid before the first rising edge, and mosi_o holds steady while sclk_o is high.
- R4: Every serial clock low phase inside a character and every high phase lasts max(half_div,1) system cycles. There are eight pulses per character, and sclk_o is 0 whenever no character is in progress.
- R5: miso_i is captured at each rising edge, most significant bit first. After the eighth falling edge, rx_data holds the captured byte and rx_done is 1.
- R6: An rx_rd pulse clears rx_done.
- R7: A byte written while a character is being shifted waits in the transmit buffer and is sent directly after it. tx_empty returns to 1 only after both characters.
- R8: A write while the transmit buffer already holds a pending byte replaces that byte. Only the newer byte is sent.
- R9: When a character completes while rx_done is still 1 and no rx_rd arrives in that cycle, rx_data is replaced and overrun becomes 1. err_clr clears overrun.
- R10: With use_grant=1 and bus_grant_i=0, sclk_oe and mosi_oe are 0, and conflict_err is 1 from the next cycle on. Shift state is held unchanged and the character resumes correctly when the grant returns. conflict_err stays 1 until err_clr.
- R11: With use_grant=0, bus_grant_i has no effect: the enables stay 1, no error is raised, and transfers complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | System cycles per serial clock half period (0 treated as 1) |
| use_grant | input | 1 | 1 selects four-pin operation with bus grant monitoring |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Byte written to the transmit buffer |
| tx_free | output | 1 | Transmit buffer can accept a byte |
| tx_empty | output | 1 | No character shifting and no byte pending |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | 8 | Receive buffer contents |
| rx_done | output | 1 | A received character is waiting |
| overrun | output | 1 | A character was lost to an unread one |
| conflict_err | output | 1 | Sticky bus conflict flag |
| err_clr | input | 1 | Clears conflict_err and overrun |
| sclk_o | output | 1 | Serial clock |
| sclk_oe | output | 1 | Output enable for sclk_o |
| mosi_o | output | 1 | Master-out data |
| mosi_oe | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Master-in data |
| bus_grant_i | input | 1 | High while this master owns the bus (four-pin only) |

## Verification
A wrong bit counter or shift register shows up on the first character as a wrong byte at rx_data, or as a wrong count of clock pulses seen on sclk_o. The divider lengthens or shortens a serial clock phase by a measurable number of system cycles within one half period. A mistake in the buffer flags shows up one or two cycles after a write, as a wrong tx_free or tx_empty level. During a bus conflict, a frozen state that is not really frozen shows up when the grant returns: the remaining bits come out of phase and the received and sent bytes mismatch.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int DW = 8;
    localparam int BW = $clog2(DW);

    typedef struct packed {
        logic          busy;
        logic          sclk;
        logic [BW-1:0] bits;
        logic [DW-1:0] sr;
        logic          samp;
        logic          done;
    } eng_t;

    typedef struct packed {
        logic [DW-1:0] tx_buf;
        logic          tx_full;
        logic [DW-1:0] rx_buf;
        logic          rx_done;
        logic          overrun;
        logic          err;
    } ctl_t;
endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             pause,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] lim;
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        lim   = (half_div == '0) ? DIV_W'(1) : half_div;
        tick  = active && !pause && (cnt_q == lim - DIV_W'(1));
        cnt_d = cnt_q;
        if (!active)    cnt_d = '0;
        else if (pause) cnt_d = cnt_q;
        else if (tick)  cnt_d = '0;
        else            cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          miso,
    output logic          busy,
    output logic          sclk,
    output logic          mosi,
    output logic          done,
    output logic [DW-1:0] rx_byte
);
    eng_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        if (!e_q.busy) begin
            e_d.sclk = 1'b0;
            if (load) begin
                e_d.busy = 1'b1;
                e_d.sr   = load_data;
                e_d.bits = '0;
            end
        end else if (tick && run) begin
            if (!e_q.sclk) begin
                e_d.sclk = 1'b1;
                e_d.samp = miso;
            end else begin
                e_d.sclk = 1'b0;
                e_d.sr   = {e_q.sr[DW-2:0], e_q.samp};
                e_d.bits = e_q.bits + BW'(1);
                if (e_q.bits == BW'(DW - 1)) begin
                    e_d.busy = 1'b0;
                    e_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign busy    = e_q.busy;
    assign sclk    = e_q.sclk;
    assign mosi    = e_q.busy ? e_q.sr[DW-1] : 1'b0;
    assign done    = e_q.done;
    assign rx_byte = e_q.sr;

    // R4: clock rests low outside a character
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !e_q.busy |-> !e_q.sclk);
    // R4: clock level only moves on a divider tick
    a_r4_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.busy && !tick) |=> $stable(e_q.sclk));
    // R10: a paused engine keeps its shift state
    a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.busy && !run) |=> ($stable(e_q.sr) && $stable(e_q.sclk) && $stable(e_q.bits)));
    // R5: completion pulse only once the engine is idle
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.done |-> !e_q.busy);
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
    import spi_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             use_grant,
    input  logic             tx_wr,
    input  logic [DW-1:0]    tx_data,
    output logic             tx_free,
    output logic             tx_empty,
    input  logic             rx_rd,
    output logic [DW-1:0]    rx_data,
    output logic             rx_done,
    output logic             overrun,
    output logic             conflict_err,
    input  logic             err_clr,
    output logic             sclk_o,
    output logic             sclk_oe,
    output logic             mosi_o,
    output logic             mosi_oe,
    input  logic             miso_i,
    input  logic             bus_grant_i
);
    ctl_t          s_d, s_q;
    logic          hold, load, tick;
    logic          eng_busy, eng_done;
    logic [DW-1:0] eng_rx;

    assign hold = use_grant && !bus_grant_i;
    assign load = s_q.tx_full && !eng_busy;

    spi_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (eng_busy),
        .pause    (hold),
        .half_div (half_div),
        .tick     (tick)
    );

    spi_shifter u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (!hold),
        .tick      (tick),
        .load      (load),
        .load_data (s_q.tx_buf),
        .miso      (miso_i),
        .busy      (eng_busy),
        .sclk      (sclk_o),
        .mosi      (mosi_o),
        .done      (eng_done),
        .rx_byte   (eng_rx)
    );

    always_comb begin
        s_d = s_q;
        if (load) s_d.tx_full = 1'b0;
        if (tx_wr) begin
            s_d.tx_buf  = tx_data;
            s_d.tx_full = 1'b1;
        end
        if (eng_done) begin
            s_d.rx_buf  = eng_rx;
            s_d.rx_done = 1'b1;
            if (s_q.rx_done && !rx_rd) s_d.overrun = 1'b1;
        end else if (rx_rd) begin
            s_d.rx_done = 1'b0;
        end
        if (err_clr) begin
            s_d.err     = 1'b0;
            s_d.overrun = 1'b0;
        end
        if (hold) s_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_free      = !s_q.tx_full;
    assign tx_empty     = !s_q.tx_full && !eng_busy;
    assign rx_data      = s_q.rx_buf;
    assign rx_done      = s_q.rx_done;
    assign overrun      = s_q.overrun;
    assign conflict_err = s_q.err;
    assign sclk_oe      = !hold;
    assign mosi_oe      = !hold;

    // R2: a write leaves the buffer occupied in the next cycle
    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_free);
    // R2: an idle transmitter shows no clock activity
    a_r2_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> !sclk_o);
    // R5: engine completion raises the receive flag
    a_r5_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> rx_done);
    // R10: conflict is latched one cycle later
    a_r10_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> conflict_err);
    // R11: three-pin mode never raises the conflict flag by itself
    a_r11_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_grant && !conflict_err && !err_clr) |=> !conflict_err);
endmodule

// File: tb/sim_spi_dbuf_master.sv
module sim_spi_dbuf_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] half_div = 8'd1;
    logic       use_grant = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rx_rd = 1'b0;
    logic       err_clr = 1'b0;
    logic       bus_grant_i = 1'b1;
    logic       miso_i;
    logic       tx_free, tx_empty, rx_done, overrun, conflict_err;
    logic [7:0] rx_data;
    logic       sclk_o, sclk_oe, mosi_o, mosi_oe;

    int total = 0;
    int bad = 0;

    // slave model state (monitor-owned)
    logic       prev_sclk = 1'b0;
    logic       cur_bit = 1'b0;
    logic [7:0] msh = 8'h00;
    int         hi_cnt = 0, lo_cnt = 0, mbits = 0, mon_cnt = 0;
    int         tim_err = 0, mosi_err = 0;
    logic [7:0] mrec [0:127];
    // test-owned
    logic [7:0] slv [0:127];
    int         exp_lim = 1;

    always #10 clk = ~clk;

    spi_dbuf_master u0 (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .use_grant(use_grant),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_free(tx_free), .tx_empty(tx_empty),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_done(rx_done), .overrun(overrun),
        .conflict_err(conflict_err), .err_clr(err_clr), .sclk_o(sclk_o),
        .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
        .bus_grant_i(bus_grant_i)
    );

    assign miso_i = slv[mon_cnt[6:0]][3'(7 - mbits)];

    always @(negedge clk) begin
        if (rst_n && sclk_oe) begin
            if (!prev_sclk && sclk_o) begin
                if (mbits > 0 && lo_cnt != exp_lim) tim_err++;
                cur_bit = mosi_o;
                msh = {msh[6:0], mosi_o};
                hi_cnt = 1;
            end else if (prev_sclk && sclk_o) begin
                hi_cnt++;
                if (mosi_o != cur_bit) mosi_err++;
            end else if (prev_sclk && !sclk_o) begin
                if (hi_cnt != exp_lim) tim_err++;
                mbits++;
                lo_cnt = 1;
                if (mbits == 8) begin
                    mbits = 0;
                    mrec[mon_cnt[6:0]] = msh;
                    mon_cnt++;
                end
            end else begin
                lo_cnt++;
            end
            prev_sclk = sclk_o;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_rx();
        for (int i = 0; i < 4000 && !rx_done; i++) @(negedge clk);
    endtask

    task automatic wait_cnt(input int n);
        for (int i = 0; i < 8000 && mon_cnt < n; i++) @(negedge clk);
        for (int i = 0; i < 4000 && !tx_empty; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rx_rd = 1'b1;
        @(negedge clk) rx_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic one_byte(input int dv, input logic [7:0] tb, input logic [7:0] mb);
        int k;
        k = mon_cnt;
        half_div = 8'(dv);
        exp_lim = (dv == 0) ? 1 : dv;
        slv[k[6:0]] = mb;
        @(negedge clk);
        tx_data = tb;
        tx_wr = 1'b1;
        @(negedge clk) tx_wr = 1'b0;
        check(tx_free == 1'b0, "R2 free low after write", int'(tx_free), 0);
        @(negedge clk);
        check(tx_free == 1'b1 && tx_empty == 1'b0, "R2 free after load, not empty",
              int'({tx_free, tx_empty}), 2);
        wait_rx();
        check(mrec[k[6:0]] == tb, "R3 mosi byte", int'(mrec[k[6:0]]), int'(tb));
        check(rx_done == 1'b1 && rx_data == mb, "R5 received byte", int'(rx_data), int'(mb));
        pulse_rd();
        check(rx_done == 1'b0 && overrun == 1'b0, "R6 read clears rx_done",
              int'({rx_done, overrun}), 0);
        check(tx_empty == 1'b1, "R2 empty after character", int'(tx_empty), 1);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            slv[i] = 8'h00;
            mrec[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        check(tx_free && tx_empty && !rx_done && !overrun && !conflict_err && !sclk_o
              && sclk_oe && mosi_oe, "R1 reset state",
              int'({tx_free, tx_empty, rx_done, overrun, conflict_err, sclk_o}), 6'h30);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6: sweep over divider values and byte patterns
        for (int dv = 0; dv < 4; dv++) begin
            for (int p = 0; p < 8; p++) begin
                one_byte(dv, 8'(p * 37 + 5 + dv * 64), 8'((p * 37 + 5) ^ 8'hA5 ^ dv));
            end
        end
        one_byte(2, 8'hFF, 8'h00);
        one_byte(2, 8'h00, 8'hFF);

        // R7 and R9: back-to-back characters, first one left unread
        begin
            int k;
            k = mon_cnt;
            half_div = 8'd2;
            exp_lim = 2;
            slv[k[6:0]] = 8'h3C;
            slv[(k + 1) & 127] = 8'hC3;
            @(negedge clk); tx_data = 8'hA1; tx_wr = 1'b1;
            @(negedge clk); tx_wr = 1'b0;
            @(negedge clk); tx_data = 8'h7E; tx_wr = 1'b1;
            @(negedge clk); tx_wr = 1'b0;
            check(tx_empty == 1'b0 && tx_free == 1'b0, "R7 second byte pending",
                  int'({tx_free, tx_empty}), 0);
            for (int i = 0; i < 4000 && mon_cnt < k + 1; i++) @(negedge clk);
            repeat (4) @(negedge clk);
            check(tx_empty == 1'b0, "R7 not empty between characters", int'(tx_empty), 0);
            wait_cnt(k + 2);
            check(mrec[k[6:0]] == 8'hA1 && mrec[(k + 1) & 127] == 8'h7E, "R7 order",
                  int'({mrec[k[6:0]], mrec[(k + 1) & 127]}), 16'hA17E);
            check(tx_empty == 1'b1, "R7 empty after both", int'(tx_empty), 1);
            check(overrun == 1'b1 && rx_data == 8'hC3 && rx_done == 1'b1, "R9 overrun set",
                  int'({overrun, rx_data}), 9'h1C3);
            pulse_clr();
            check(overrun == 1'b0, "R9 clear overrun", int'(overrun), 0);
            pulse_rd();
        end

        // R8: three writes in a row, middle one replaced
        begin
            int k;
            k = mon_cnt;
            half_div = 8'd1;
            exp_lim = 1;
            slv[k[6:0]] = 8'h11;
            slv[(k + 1) & 127] = 8'h22;
            slv[(k + 2) & 127] = 8'h33;
            @(negedge clk); tx_data = 8'hB1; tx_wr = 1'b1;
            @(negedge clk); tx_data = 8'hB2;
            @(negedge clk); tx_data = 8'hB3;
            @(negedge clk); tx_wr = 1'b0;
            wait_cnt(k + 2);
            repeat (40) @(negedge clk);
            check(mon_cnt == k + 2, "R8 only two characters", mon_cnt - k, 2);
            check(mrec[k[6:0]] == 8'hB1 && mrec[(k + 1) & 127] == 8'hB3, "R8 replaced byte",
                  int'({mrec[k[6:0]], mrec[(k + 1) & 127]}), 16'hB1B3);
            pulse_clr();
            pulse_rd();
        end

        // R10: grant lost mid-character, then restored
        begin
            int k;
            int mb;
            k = mon_cnt;
            use_grant = 1'b1;
            half_div = 8'd3;
            exp_lim = 3;
            slv[k[6:0]] = 8'h96;
            @(negedge clk); tx_data = 8'h5A; tx_wr = 1'b1;
            @(negedge clk); tx_wr = 1'b0;
            for (int i = 0; i < 2000 && mbits < 3; i++) @(negedge clk);
            @(posedge clk); #1 bus_grant_i = 1'b0;
            @(negedge clk);
            check(sclk_oe == 1'b0 && mosi_oe == 1'b0, "R10 outputs released",
                  int'({sclk_oe, mosi_oe}), 0);
            @(negedge clk);
            check(conflict_err == 1'b1, "R10 error set", int'(conflict_err), 1);
            mb = mbits;
            repeat (30) @(negedge clk);
            check(mbits == mb && rx_done == 1'b0, "R10 state held", mbits, mb);
            @(posedge clk); #1 bus_grant_i = 1'b1;
            wait_rx();
            check(mrec[k[6:0]] == 8'h5A && rx_data == 8'h96, "R10 resumes intact",
                  int'({mrec[k[6:0]], rx_data}), 16'h5A96);
            check(conflict_err == 1'b1, "R10 error sticky", int'(conflict_err), 1);
            pulse_clr();
            check(conflict_err == 1'b0, "R10 err_clr", int'(conflict_err), 0);
            pulse_rd();
            // idle conflict also flags
            @(negedge clk) bus_grant_i = 1'b0;
            repeat (2) @(negedge clk);
            check(conflict_err == 1'b1 && !sclk_oe, "R10 idle conflict", int'(conflict_err), 1);
            bus_grant_i = 1'b1;
            pulse_clr();
        end

        // R11: grant input ignored in three-pin mode
        use_grant = 1'b0;
        @(negedge clk) bus_grant_i = 1'b0;
        @(negedge clk);
        check(sclk_oe == 1'b1 && mosi_oe == 1'b1, "R11 enables stay", int'({sclk_oe, mosi_oe}), 3);
        one_byte(1, 8'hC9, 8'h4D);
        check(conflict_err == 1'b0, "R11 no error", int'(conflict_err), 0);
        bus_grant_i = 1'b1;

        check(tim_err == 0, "R4 clock phase lengths", tim_err, 0);
        check(mosi_err == 0, "R3 mosi stable while high", mosi_err, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule